// File: doc/BRIEF.md
# Bus Access Trigger Sequencer

This block watches a processor bus made of a 16-bit address, an 8-bit data byte, a write flag and a valid strobe. It holds two comparator conditions, A and B, and turns their matches into a breakpoint pulse or a trace-record pulse according to a 4-bit mode. The modes cover a single condition, either condition, A followed later by B, an address-plus-data test with equal or unequal data, and an address window whose bounds come from the two conditions. Two modes feed trace capture only.

Software loads the conditions and the mode through a small write port. It then pulses `arm_i` to start watching. `clear_i` stops the watch and wipes the status. Each cycle the raw A and B match flags are also driven out, so a trace unit can use them without waiting for a register stage.

Top module: `bus_trig_seq`

## Requirements
- R1: After reset `trig_o`, `rec_o` and `sticky_o` are low, the mode is 0, the block is disarmed, both condition addresses are 0 and both access-type masks are 0.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` according to `cfg_addr_i`: 0 gives the A address, 1 gives the A type mask (bits 1:0), 2 gives the B address, 3 gives the B type mask (bits 1:0), 4 gives the B data byte (bits 7:0) and 5 gives the mode (bits 3:0). Addresses 6 and 7 are ignored. Mode codes: 1 A, 2 A or B, 3 A then B, 4 A and B-data, 5 A and not B-data, 6 inside range, 7 outside range, 8 record B, 9 A then record B. Codes 0 and 10 to 15 produce no pulse.
- R3: `match_a_o` and `match_b_o` are combinational. Each is high when `bus_valid_i` is high, the address equals that condition's address, and that condition's type mask permits the access. Mask bit 0 permits reads (`bus_wr_i`=0) and mask bit 1 permits writes. The flags do not depend on the mode or on the arm state.
- R4: A qualifying bus cycle produces a one-clock pulse on `trig_o` (or `rec_o`) at the next rising edge, and only while the block is armed. `arm_i` arms the block and `clear_i` disarms it. `clear_i` wins over `arm_i` and suppresses any pulse from its own cycle.
- R5: Mode 1 fires on an A match. Mode 2 fires on an A or a B match.
- R6: Mode 3 fires on a B match only when an A match was latched in an earlier cycle. A cycle that matches both A and B does not fire. The latch is set by an armed A match. It is cleared by `arm_i`, by `clear_i` and by any write to the mode register.
- R7: Mode 4 fires when A matches and the bus data equals the B data byte. Mode 5 fires when A matches and the bus data differs from the B data byte.
- R8: Mode 6 fires on a valid cycle that A's type mask permits and whose address lies within the inclusive range from the A address (lower bound) to the B address (upper bound). Mode 7 fires on such a cycle whose address lies outside that range. When A is greater than B, mode 6 never fires.
- R9: Mode 8 pulses `rec_o` on every B match. Mode 9 pulses `rec_o` on a B match once an A match has been latched, following the R6 rules. Neither mode ever asserts `trig_o`.
- R10: `sticky_o` rises together with the first `trig_o` pulse and stays high until `clear_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 8 | Bus data byte |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| arm_i | input | 1 | Arm and reset the A latch |
| clear_i | input | 1 | Disarm, clear status and the A latch |
| match_a_o | output | 1 | Per-cycle condition A match |
| match_b_o | output | 1 | Per-cycle condition B match |
| trig_o | output | 1 | Breakpoint/trigger pulse |
| rec_o | output | 1 | Trace record pulse |
| sticky_o | output | 1 | Trigger seen since last clear |

## Verification
The delicate collisions are an A match and a B match in the same cycle in sequential mode, and a control action (`arm_i`, `clear_i` or a mode write) in the same cycle as a qualifying bus access. The bench provokes the first case by giving A and B the same address. It provokes the second by pulsing the controls alongside matching bus cycles, both in directed steps and in a long random phase. A behavioural reference model predicts every output for every clock. The bench requires that the same-cycle A-and-B hit stays silent, that a clear or re-arm forgets the latched A, and that a clear suppresses the pulse of its own cycle.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [3:0] {
    MODE_OFF          = 4'd0,
    MODE_A            = 4'd1,
    MODE_A_OR_B       = 4'd2,
    MODE_A_THEN_B     = 4'd3,
    MODE_A_AND_BD     = 4'd4,
    MODE_A_NOT_BD     = 4'd5,
    MODE_IN_RANGE     = 4'd6,
    MODE_OUT_RANGE    = 4'd7,
    MODE_REC_B        = 4'd8,
    MODE_A_THEN_REC_B = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    REG_A_ADDR = 3'd0,
    REG_A_TYPE = 3'd1,
    REG_B_ADDR = 3'd2,
    REG_B_TYPE = 3'd3,
    REG_B_DATA = 3'd4,
    REG_MODE   = 3'd5
  } reg_e;

  localparam int unsigned TYPE_W = 2;
  localparam int unsigned MODE_W = 4;
endpackage

// File: rtl/bts_cfg_regs.sv
module bts_cfg_regs
  import bts_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WD_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        waddr_i,
  input  logic [WD_W-1:0]   wdata_i,
  output logic [ADDR_W-1:0] a_addr_o,
  output logic [TYPE_W-1:0] a_type_o,
  output logic [ADDR_W-1:0] b_addr_o,
  output logic [TYPE_W-1:0] b_type_o,
  output logic [DATA_W-1:0] b_data_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_wr_o
);
  assign mode_wr_o = we_i && (waddr_i == REG_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_addr_o <= '0;
      a_type_o <= '0;
      b_addr_o <= '0;
      b_type_o <= '0;
      b_data_o <= '0;
      mode_o   <= MODE_OFF;
    end else if (we_i) begin
      case (waddr_i)
        REG_A_ADDR: a_addr_o <= wdata_i[ADDR_W-1:0];
        REG_A_TYPE: a_type_o <= wdata_i[TYPE_W-1:0];
        REG_B_ADDR: b_addr_o <= wdata_i[ADDR_W-1:0];
        REG_B_TYPE: b_type_o <= wdata_i[TYPE_W-1:0];
        REG_B_DATA: b_data_o <= wdata_i[DATA_W-1:0];
        REG_MODE:   mode_o   <= wdata_i[MODE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bts_cmp.sv
module bts_cmp
  import bts_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              valid_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ref_addr_i,
  input  logic [TYPE_W-1:0] ref_type_i,
  output logic              match_o
);
  logic type_ok;
  // mask bit 0 permits reads, bit 1 permits writes
  assign type_ok = wr_i ? ref_type_i[1] : ref_type_i[0];
  assign match_o = valid_i && type_ok && (addr_i == ref_addr_i);
endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [TYPE_W-1:0] a_type_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              mode_wr_i,
  input  logic              match_a_i,
  input  logic              match_b_i,
  input  logic              arm_i,
  input  logic              clear_i,
  output logic              trig_o,
  output logic              rec_o,
  output logic              sticky_o
);
  logic armed_q, a_seen_q;
  logic a_acc, in_rng;
  logic brk_hit, rec_hit, seq_mode;

  assign a_acc  = bus_valid_i && (bus_wr_i ? a_type_i[1] : a_type_i[0]);
  assign in_rng = a_acc && (bus_addr_i >= a_addr_i) && (bus_addr_i <= b_addr_i);

  always_comb begin
    brk_hit  = 1'b0;
    rec_hit  = 1'b0;
    seq_mode = 1'b0;
    case (mode_i)
      MODE_A:            brk_hit = match_a_i;
      MODE_A_OR_B:       brk_hit = match_a_i || match_b_i;
      MODE_A_THEN_B: begin
        seq_mode = 1'b1;
        brk_hit  = match_b_i && a_seen_q;
      end
      MODE_A_AND_BD:     brk_hit = match_a_i && (bus_data_i == b_data_i);
      MODE_A_NOT_BD:     brk_hit = match_a_i && (bus_data_i != b_data_i);
      MODE_IN_RANGE:     brk_hit = in_rng;
      MODE_OUT_RANGE:    brk_hit = a_acc && !in_rng;
      MODE_REC_B:        rec_hit = match_b_i;
      MODE_A_THEN_REC_B: begin
        seq_mode = 1'b1;
        rec_hit  = match_b_i && a_seen_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      a_seen_q <= 1'b0;
      trig_o   <= 1'b0;
      rec_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      trig_o <= armed_q && !clear_i && brk_hit;
      rec_o  <= armed_q && !clear_i && rec_hit;
      if (clear_i)     armed_q <= 1'b0;
      else if (arm_i)  armed_q <= 1'b1;
      if (clear_i || arm_i || mode_wr_i)             a_seen_q <= 1'b0;
      else if (armed_q && seq_mode && match_a_i)     a_seen_q <= 1'b1;
      if (clear_i)                                   sticky_o <= 1'b0;
      else if (armed_q && brk_hit)                   sticky_o <= 1'b1;
    end
  end

  a_r9_rec_never_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !rec_o);
  a_r10_sticky_with_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> sticky_o);
  a_r4_clear_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (!trig_o && !rec_o && !sticky_o));
  a_r4_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o || rec_o) |-> $past(bus_valid_i));
  a_r2_unused_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i == MODE_OFF || mode_i > MODE_A_THEN_REC_B) |-> (!trig_o && !rec_o));
  a_r6_no_fire_without_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i == MODE_A_THEN_B && !a_seen_q) |-> !trig_o);
  a_r8_inverted_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i == MODE_IN_RANGE && a_addr_i > b_addr_i) |-> !trig_o);
endmodule

// File: rtl/bus_trig_seq.sv
module bus_trig_seq
  import bts_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [(ADDR_W > DATA_W ? ADDR_W : DATA_W)-1:0] cfg_wdata_i,
  input  logic              arm_i,
  input  logic              clear_i,
  output logic              match_a_o,
  output logic              match_b_o,
  output logic              trig_o,
  output logic              rec_o,
  output logic              sticky_o
);
  localparam int unsigned WD_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int unsigned N_CMP = 2;

  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [TYPE_W-1:0] a_type, b_type;
  logic [DATA_W-1:0] b_data;
  logic [MODE_W-1:0] mode;
  logic              mode_wr;
  logic [ADDR_W-1:0] ref_addr [N_CMP];
  logic [TYPE_W-1:0] ref_type [N_CMP];
  logic [N_CMP-1:0]  match;

  bts_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WD_W(WD_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .waddr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .a_addr_o(a_addr), .a_type_o(a_type), .b_addr_o(b_addr), .b_type_o(b_type),
    .b_data_o(b_data), .mode_o(mode), .mode_wr_o(mode_wr)
  );

  assign ref_addr[0] = a_addr;
  assign ref_addr[1] = b_addr;
  assign ref_type[0] = a_type;
  assign ref_type[1] = b_type;

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    bts_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .valid_i(bus_valid_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
      .ref_addr_i(ref_addr[i]), .ref_type_i(ref_type[i]), .match_o(match[i])
    );
  end

  assign match_a_o = match[0];
  assign match_b_o = match[1];

  bts_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .bus_valid_i, .bus_wr_i, .bus_addr_i, .bus_data_i,
    .a_addr_i(a_addr), .a_type_i(a_type), .b_addr_i(b_addr), .b_data_i(b_data),
    .mode_i(mode), .mode_wr_i(mode_wr),
    .match_a_i(match[0]), .match_b_i(match[1]),
    .arm_i, .clear_i,
    .trig_o, .rec_o, .sticky_o
  );
endmodule

// File: tb/bus_trig_seq_bench.sv
`timescale 1ns/1ps
module bus_trig_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 0, wr = 0, we = 0, arm = 0, clr = 0;
  logic [15:0] addr = 0, wd = 0;
  logic [7:0]  data = 0;
  logic [2:0]  ra = 0;
  logic m_a, m_b, trig, rec, sticky;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  int  e_aaddr, e_atype, e_baddr, e_btype, e_bdata, e_mode;
  bit  e_armed, e_seen, e_trig, e_rec, e_sticky;

  always #2 clk = ~clk;

  bus_trig_seq u_bus_trig_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(v), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_data_i(data), .cfg_we_i(we), .cfg_addr_i(ra), .cfg_wdata_i(wd),
    .arm_i(arm), .clear_i(clr), .match_a_o(m_a), .match_b_o(m_b),
    .trig_o(trig), .rec_o(rec), .sticky_o(sticky)
  );

  function automatic bit permit(int t, bit w);
    return w ? t[1] : t[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_aaddr = 0; e_atype = 0; e_baddr = 0; e_btype = 0; e_bdata = 0; e_mode = 0;
      e_armed = 0; e_seen = 0; e_trig = 0; e_rec = 0; e_sticky = 0;
    end else begin
      bit ma, mb, acc, ins, bh, rh, sq;
      ma  = v && permit(e_atype, wr) && addr == e_aaddr;
      mb  = v && permit(e_btype, wr) && addr == e_baddr;
      acc = v && permit(e_atype, wr);
      ins = acc && addr >= e_aaddr && addr <= e_baddr;
      bh = 0; rh = 0; sq = (e_mode == 3 || e_mode == 9);
      case (e_mode)
        1: bh = ma;
        2: bh = ma || mb;
        3: bh = mb && e_seen;
        4: bh = ma && data == e_bdata;
        5: bh = ma && data != e_bdata;
        6: bh = ins;
        7: bh = acc && !ins;
        8: rh = mb;
        9: rh = mb && e_seen;
        default: ;
      endcase
      e_trig = e_armed && !clr && bh;
      e_rec  = e_armed && !clr && rh;
      if (clr) e_sticky = 0; else if (e_trig) e_sticky = 1;
      if (clr || arm || (we && ra == 5)) e_seen = 0;
      else if (e_armed && sq && ma) e_seen = 1;
      if (clr) e_armed = 0; else if (arm) e_armed = 1;
      if (we) case (ra)
        0: e_aaddr = wd;
        1: e_atype = wd & 3;
        2: e_baddr = wd;
        3: e_btype = wd & 3;
        4: e_bdata = wd & 8'hFF;
        5: e_mode  = wd & 4'hF;
        default: ;
      endcase
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic chk_regs();
    chk("trig_o", trig, e_trig);
    chk("rec_o", rec, e_rec);
    chk("sticky_o", sticky, e_sticky);
  endtask

  task automatic cyc(bit vv, bit ww, logic [15:0] aa, logic [7:0] dd,
                     bit cwe, logic [2:0] cra, logic [15:0] cwd, bit aarm, bit cclr);
    @(negedge clk);
    chk_regs();
    v = vv; wr = ww; addr = aa; data = dd; we = cwe; ra = cra; wd = cwd; arm = aarm; clr = cclr;
    #1;
    chk("match_a_o", m_a, vv && permit(e_atype, ww) && aa == e_aaddr);
    chk("match_b_o", m_b, vv && permit(e_btype, ww) && aa == e_baddr);
  endtask

  task automatic bus(bit ww, logic [15:0] aa, logic [7:0] dd = 8'h00);
    cyc(1, ww, aa, dd, 0, 0, 0, 0, 0);
  endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wcfg(logic [2:0] r, logic [15:0] val); cyc(0, 0, 0, 0, 1, r, val, 0, 0); endtask
  task automatic do_arm(); cyc(0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic do_clr(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic set_mode(int m); wcfg(5, 16'(m)); do_arm(); endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; idle(); idle();
    cur_req = "R2";
    wcfg(0, 16'h1000); wcfg(1, 3); wcfg(2, 16'h2000); wcfg(3, 3); wcfg(4, 16'h005A);
    wcfg(6, 16'hFFFF); wcfg(7, 16'hFFFF);           // ignored
    cur_req = "R4"; wcfg(5, 1); bus(0, 16'h1000); idle();   // unarmed: silent
    cur_req = "R5"; do_arm(); bus(0, 16'h1000); bus(1, 16'h2000); bus(1, 16'h1000); idle();
    set_mode(2); bus(0, 16'h2000); bus(1, 16'h1000); bus(0, 16'h1234); idle();
    cur_req = "R3"; wcfg(1, 1); bus(1, 16'h1000); bus(0, 16'h1000); wcfg(1, 2);
    bus(0, 16'h1000); bus(1, 16'h1000); wcfg(1, 3); idle();
    cur_req = "R6"; set_mode(3); bus(0, 16'h2000); bus(0, 16'h1000); bus(0, 16'h2000); idle();
    do_arm(); bus(0, 16'h2000); idle();                     // arm forgets A
    bus(0, 16'h1000); wcfg(5, 3); bus(0, 16'h2000); idle(); // mode write forgets A
    bus(0, 16'h1000); do_clr(); do_arm(); bus(0, 16'h2000); idle(); // clear forgets A
    wcfg(2, 16'h1000); do_arm(); bus(0, 16'h1000); bus(0, 16'h1000); idle(); // same cycle
    wcfg(2, 16'h2000);
    cur_req = "R7"; set_mode(4); bus(1, 16'h1000, 8'h5A); bus(1, 16'h1000, 8'h5B); bus(1, 16'h1001, 8'h5A); idle();
    set_mode(5); bus(1, 16'h1000, 8'h5A); bus(1, 16'h1000, 8'h00); idle();
    cur_req = "R8"; set_mode(6);
    bus(0, 16'h0FFF); bus(0, 16'h1000); bus(0, 16'h1800); bus(0, 16'h2000); bus(0, 16'h2001); idle();
    set_mode(7); bus(0, 16'h0FFF); bus(0, 16'h1000); bus(0, 16'h2000); bus(0, 16'h2001); idle();
    wcfg(0, 16'h3000); set_mode(6); bus(0, 16'h2000); bus(0, 16'h2800); bus(0, 16'h3000); idle();
    wcfg(0, 16'h1000);
    cur_req = "R9"; set_mode(8); bus(0, 16'h2000); bus(0, 16'h1000); idle();
    set_mode(9); bus(0, 16'h2000); bus(0, 16'h1000); bus(0, 16'h2000); bus(1, 16'h2000); idle();
    cur_req = "R2"; set_mode(0); bus(0, 16'h1000); set_mode(12); bus(0, 16'h1000); bus(0, 16'h2000); idle();
    cur_req = "R10"; set_mode(1); bus(0, 16'h1000); idle(); idle(); bus(0, 16'h1234); idle();
    cyc(1, 0, 16'h1000, 0, 0, 0, 0, 0, 1); idle();           // R4: clear suppresses own cycle
    cyc(1, 0, 16'h1000, 0, 0, 0, 0, 1, 1); bus(0, 16'h1000); idle(); // clear beats arm
    cur_req = "R6 random";
    for (int i = 0; i < 3000; i++) begin
      int sel; logic [15:0] a; logic [7:0] d; bit cwe; logic [2:0] cra; logic [15:0] cwd;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 16'h1000 : (sel == 1) ? 16'h2000 : (sel == 2) ? 16'h1800 : 16'($urandom);
      d = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'($urandom);
      cwe = ($urandom_range(0, 15) == 0);
      cra = 3'($urandom_range(0, 7));
      cwd = (cra == 5) ? 16'($urandom_range(0, 15)) :
            (cra == 1 || cra == 3) ? 16'($urandom_range(0, 3)) :
            (cra == 0) ? 16'($urandom_range(16'h0FF0, 16'h1010)) :
            (cra == 2) ? 16'($urandom_range(16'h1FF0, 16'h2010)) : 16'h005A;
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0, a, d, cwe, cra, cwd,
          $urandom_range(0, 19) == 0, $urandom_range(0, 39) == 0);
    end
    idle();
    @(negedge clk); chk_regs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule